// File: doc/BRIEF.md
# Video Line Selection Gate

This block picks one scan line, or a run of neighbouring scan lines, out of every field or frame of a video stream. It works only from digital timing: a one-bit composite sync level, a vertical reference pulse and a field-index level, all sampled in the system clock domain. When a reference arrives, a down counter is loaded with the requested line number plus two. Each later sync transition, rising or falling, steps that counter. The transition that brings it to its terminal value raises a gate output. The gate can drive an external video switch so that only the chosen lines pass through.

The gate stays open for a programmable number of line periods, two sync transitions per line. When it closes, the block disarms itself and ignores all further sync activity until the next reference. If the reference is the vertical pulse that starts at the first serration, line 14 opens on the sixteenth transition in either field. In field mode the field-index level acts as the reference instead, so a line is picked in one field only.

Top module: `vline_gate`

## Requirements
- R1: After reset `gate_o` is low, and sync transitions seen before the first reference leave it low.
- R2: With `field_mode_i`=0, a falling edge of `vpulse_i` loads the counter with (`line_sel_i` + 2) mod 2^LINE_W and arms the block.
- R3: While armed and not gating, every `csync_i` transition in either direction counts once. `gate_o` rises on transition number (`line_sel_i` + 2) after the reference; line_sel 14 opens on the 16th transition.
- R4: `gate_o` stays high for 2·N further transitions and falls on the 2·N-th, where N is `run_len_i`; N=0 behaves as N=1.
- R5: Once `gate_o` falls, the block is disarmed and further sync transitions have no effect until the next reference edge.
- R6: A `line_sel_i` whose preload is zero (2^LINE_W − 2, which is 2046 at the default width) selects nothing, and `gate_o` stays low for that field.
- R7: With `field_mode_i`=1, `vpulse_i` is ignored. The reference is `field_i` when `odd_sel_i`=0, so it loads on a falling edge of `field_i`. It is the inverse of `field_i` when `odd_sel_i`=1, so it loads on a rising edge.
- R8: A new reference edge while counting or gating drops `gate_o` and restarts counting from the new preload.
- R9: A change on `csync_i` or on the reference moves `gate_o` at the second rising clock edge after the change, counting one sampling register and one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csync_i | input | 1 | Composite sync level, asynchronous |
| vpulse_i | input | 1 | Vertical reference pulse; its falling edge loads |
| field_i | input | 1 | Field-index level |
| field_mode_i | input | 1 | 0 = vertical pulse reference, 1 = field-index reference |
| odd_sel_i | input | 1 | In field mode, 1 inverts the field index before edge detection |
| line_sel_i | input | LINE_W | Requested line number |
| run_len_i | input | RUN_W | Number of contiguous lines N (0 treated as 1) |
| gate_o | output | 1 | High during the selected lines |

## Verification
Every input change takes effect on the second rising clock edge after it is applied. The bench therefore drives at falling clock edges and reads `gate_o` three falling edges after each sync toggle, when the result has settled. One directed check reads the gate at the first and the second falling edge after a toggle, to pin the R9 latency to that exact edge. References are spaced at least four cycles from any sync toggle, so a load and a count never fall in the same cycle. Expected gate levels come from a bench function of the transition index, the preload and the run length.

// File: rtl/vlg_pkg.sv
package vlg_pkg;
  typedef enum logic [0:0] {EDGE_BOTH = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
  typedef enum logic [0:0] {REF_VERT = 1'b0, REF_FIELD = 1'b1} ref_src_e;
endpackage

// File: rtl/vlg_edge_det.sv
module vlg_edge_det
  import vlg_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_BOTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic pulse
);
  logic s_now, s_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_now <= 1'b0;
      s_old <= 1'b0;
    end else begin
      s_now <= d;
      s_old <= s_now;
    end
  end

  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign pulse = s_old & ~s_now;
    end else begin : g_both
      assign pulse = s_old ^ s_now;
    end
  endgenerate
endmodule

// File: rtl/vlg_line_counter.sv
module vlg_line_counter #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [LINE_W-1:0] preload,
  input  logic              gating,
  input  logic              done,
  output logic              armed,
  output logic              hit
);
  logic [LINE_W-1:0] cnt;
  logic              counting;

  assign counting = armed & ~gating;
  assign hit      = counting & step & ~load & (cnt == LINE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= preload;
      armed <= (preload != '0);
    end else if (done) begin
      armed <= 1'b0;
    end else if (counting && step) begin
      cnt <= cnt - LINE_W'(1);
    end
  end

  // R5: an idle counter does not move
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> $stable(cnt));
  // R6: zero preload never arms
  a_r6_zero_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (load && preload == '0) |=> !armed);
endmodule

// File: rtl/vlg_run_timer.sv
module vlg_run_timer #(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic             abort,
  input  logic [RUN_W-1:0] run_len,
  output logic             gate,
  output logic             done
);
  localparam int REM_W = RUN_W + 1;

  function automatic logic [REM_W-1:0] edges_for(input logic [RUN_W-1:0] n);
    logic [RUN_W-1:0] lines;
    lines = (n == '0) ? RUN_W'(1) : n;
    return {lines, 1'b0};
  endfunction

  logic [REM_W-1:0] rem;

  assign done = gate & step & ~abort & (rem == REM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate <= 1'b0;
      rem  <= '0;
    end else if (abort) begin
      gate <= 1'b0;
    end else if (start) begin
      gate <= 1'b1;
      rem  <= edges_for(run_len);
    end else if (gate && step) begin
      rem <= rem - REM_W'(1);
      if (rem == REM_W'(1)) gate <= 1'b0;
    end
  end

  // R4: the gate closes only on a counted transition or a reload
  a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> $past(step || abort));
endmodule

// File: rtl/vline_gate.sv
module vline_gate
  import vlg_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int RUN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csync_i,
  input  logic              vpulse_i,
  input  logic              field_i,
  input  logic              field_mode_i,
  input  logic              odd_sel_i,
  input  logic [LINE_W-1:0] line_sel_i,
  input  logic [RUN_W-1:0]  run_len_i,
  output logic              gate_o
);
  function automatic logic [LINE_W-1:0] preload_of(input logic [LINE_W-1:0] sel);
    return sel + LINE_W'(2);
  endfunction

  ref_src_e          ref_src;
  logic              ref_raw;
  logic              sync_edge;
  logic              ref_fall;
  logic [LINE_W-1:0] preload;
  logic              armed;
  logic              hit;
  logic              done;

  assign ref_src = ref_src_e'(field_mode_i);
  assign ref_raw = (ref_src == REF_FIELD) ? (field_i ^ odd_sel_i) : vpulse_i;
  assign preload = preload_of(line_sel_i);

  vlg_edge_det #(.KIND(EDGE_BOTH)) u_sync_edge (
    .clk(clk), .rst_n(rst_n), .d(csync_i), .pulse(sync_edge)
  );

  vlg_edge_det #(.KIND(EDGE_FALL)) u_ref_edge (
    .clk(clk), .rst_n(rst_n), .d(ref_raw), .pulse(ref_fall)
  );

  vlg_line_counter #(.LINE_W(LINE_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(ref_fall), .step(sync_edge),
    .preload(preload), .gating(gate_o), .done(done),
    .armed(armed), .hit(hit)
  );

  vlg_run_timer #(.RUN_W(RUN_W)) u_run (
    .clk(clk), .rst_n(rst_n), .start(hit), .step(sync_edge),
    .abort(ref_fall), .run_len(run_len_i), .gate(gate_o), .done(done)
  );

  // R3: the gate opens only on a sync transition
  a_r3_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(sync_edge));
  // R2: an open gate always belongs to an armed field
  a_r2_gate_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> armed);
  // R5: the end of a run disarms the block
  a_r5_disarm_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o) && !$past(ref_fall)) |-> !armed);
  // R8: a reference edge closes the gate
  a_r8_reload_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fall |=> !gate_o);
endmodule

// File: tb/vline_gate_test.sv
module vline_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 11;
  localparam int RUN_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync = 1'b0, vpulse = 1'b0, field = 1'b0, fmode = 1'b0, oddsel = 1'b0;
  logic [LINE_W-1:0] lsel = '0;
  logic [RUN_W-1:0]  rlen = '0;
  logic gate;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vline_gate #(.LINE_W(LINE_W), .RUN_W(RUN_W)) uut (
    .clk(clk), .rst_n(rst_n), .csync_i(csync), .vpulse_i(vpulse),
    .field_i(field), .field_mode_i(fmode), .odd_sel_i(oddsel),
    .line_sel_i(lsel), .run_len_i(rlen), .gate_o(gate)
  );

  function automatic int exp_preload(int sel);
    return (sel + 2) % (1 << LINE_W);
  endfunction

  function automatic bit exp_gate(int p, int n, int k);
    int nn;
    nn = (n == 0) ? 1 : n;
    return (p != 0) && (k >= p) && (k < p + 2 * nn);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gate actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic toggle();
    @(negedge clk) csync = ~csync;
    repeat (3) @(negedge clk);
  endtask

  task automatic vref();
    @(negedge clk) vpulse = 1'b1;
    repeat (3) @(negedge clk);
    vpulse = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fref(bit odd);
    @(negedge clk) field = odd ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    field = odd ? 1'b1 : 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_field(string req, int sel, int n, bit mode, bit odd, int extra);
    int p, ntog;
    lsel = LINE_W'(sel);
    rlen = RUN_W'(n);
    fmode = mode;
    oddsel = odd;
    repeat (4) @(negedge clk);
    if (mode) fref(odd); else vref();
    check({req, " after load"}, gate, 1'b0);
    p = exp_preload(sel);
    ntog = (p == 0) ? 20 : p + 2 * ((n == 0) ? 1 : n) + extra;
    for (int k = 1; k <= ntog; k++) begin
      toggle();
      check(req, gate, exp_gate(p, n, k));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd1881);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state and no counting before a reference
    check("R1 reset", gate, 1'b0);
    for (int k = 0; k < 6; k++) begin
      toggle();
      check("R1 unarmed", gate, 1'b0);
    end

    // R2 R3: line 14 opens on the 16th transition
    run_field("R3 line14", 14, 1, 1'b0, 1'b0, 4);
    // R4: contiguous run, and N=0 acts as one line
    run_field("R4 run3", 5, 3, 1'b0, 1'b0, 4);
    run_field("R4 run0", 2, 0, 1'b0, 1'b0, 4);
    // R6: zero preload selects nothing
    run_field("R6 zero", (1 << LINE_W) - 2, 2, 1'b0, 1'b0, 0);
    // R2: wrap to preload 1 opens on first transition
    run_field("R2 wrap", (1 << LINE_W) - 1, 1, 1'b0, 1'b0, 3);
    // R2: large line number
    run_field("R2 far", 300, 2, 1'b0, 1'b0, 3);
    // R7: field reference, each polarity
    run_field("R7 even", 7, 2, 1'b1, 1'b0, 3);
    run_field("R7 odd", 4, 1, 1'b1, 1'b1, 3);

    // R7: vertical pulse ignored in field mode after the run ended
    vref();
    for (int k = 0; k < 6; k++) begin
      toggle();
      check("R7 vpulse ignored", gate, 1'b0);
    end
    // R7: field index ignored in vertical mode
    fmode = 1'b0;
    repeat (4) @(negedge clk);
    fref(1'b0);
    for (int k = 0; k < 6; k++) begin
      toggle();
      check("R7 field ignored", gate, 1'b0);
    end

    // R9: latency of two rising edges
    lsel = LINE_W'(0);
    rlen = RUN_W'(1);
    vref();
    toggle();
    check("R9 pre", gate, 1'b0);
    @(negedge clk) csync = ~csync;
    @(negedge clk);
    check("R9 one edge", gate, 1'b0);
    @(negedge clk);
    check("R9 two edges", gate, 1'b1);
    repeat (2) @(negedge clk);

    // R8: reload while gating drops the gate and restarts
    lsel = LINE_W'(1);
    rlen = RUN_W'(2);
    vref();
    check("R8 dropped", gate, 1'b0);
    for (int k = 1; k <= 9; k++) begin
      toggle();
      check("R8 restart", gate, exp_gate(3, 2, k));
    end

    // R5: after a run, transitions do nothing
    for (int k = 0; k < 8; k++) begin
      toggle();
      check("R5 disarmed", gate, 1'b0);
    end

    // random fields, mixed modes
    for (int f = 0; f < 25; f++) begin
      int s, n;
      s = int'($urandom % 40);
      n = int'($urandom % 6);
      run_field("R3 R4 random", s, n, 1'($urandom % 2), 1'($urandom % 2), 2);
    end

    finish_run();
  end
endmodule